// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits behind the single host data port of a network controller and turns each host access into a read or write of the controller's local buffer memory. A remote address pointer and a remaining-byte count are loaded from outside. Every host access then moves one, two or four bytes at the pointer. The engine packs the bytes little-endian and advances the pointer. The pointer wraps from the ring stop page back to the ring start page. The count runs down, and a one-cycle completion pulse is issued when the count is used up.

The local address space holds two windows. The first is a 32-byte station-address store that the engine keeps itself and loads at reset. The second is packet memory from byte 16384 up to byte 32767, held in an external RAM of four byte-wide lanes with a one-cycle read latency. An access outside both windows leaves memory untouched and reads back as all ones. The current pointer and count are brought out as ports so that the surrounding register file can show them.

Top module: `rdma_port_engine`

## Requirements
- R1: On reset, busy, read-valid, done, pointer and count are all 0. Store byte 2i and byte 2i+1 hold source byte i. Source bytes 0..5 are the station address, lowest byte first (`station_addr[7:0]` is byte 0). Source bytes 14 and 15 are 0x57, and all other source bytes are 0.
- R2: A strobe with `port_size` of 2 or 3 is a 4-byte access with step 4. Otherwise the access is 2 bytes with step 2 when `wide16` is 1, and 1 byte with step 1 when `wide16` is 0.
- R3: For 2- and 4-byte accesses, address bit 0 is treated as 0 for the memory access. The byte at the lowest address travels in data bits 7:0. The pointer advance starts from the unaligned pointer value.
- R4: An access is valid when its aligned address is below 32, or when it is at least 16384 and the address plus the byte count is at most 32768. In a store-window access, bytes that land at 32 or above read as 0x00 and are not written. Packet byte x uses lane (x-16384) mod 4 and row (x-16384)/4 of the RAM port.
- R5: An invalid access drives no RAM enable and changes no stored byte. A read returns 0xFF in each of its low n bytes and 0 above them.
- R6: After each access, the pointer becomes pointer+step (modulo 2^16). If that equals `ring_stop_pg`*256, the pointer becomes `ring_start_pg`*256 instead.
- R7: After each access, when count <= step the count becomes 0 and `dma_done` is high for exactly one cycle. Otherwise the count drops by the step.
- R8: A write strobe while the count is 0 is ignored. No memory changes, the pointer and count stay the same, and no `dma_done` is raised.
- R9: A read strobe while the count is 0 still returns data, advances the pointer and raises `dma_done`.
- R10: Read data and `port_rvalid` appear in the cycle after the accepting edge, with `port_busy` high in that cycle. A strobe that arrives while busy is ignored. The updated pointer and count, and `dma_done`, appear one cycle later.
- R11: `cfg_load` while not busy loads the pointer and count, which are visible in the next cycle. A strobe in the same cycle as the load is dropped, and a load while busy is ignored.
- R12: A valid write with a nonzero count into the store window changes the stored bytes, and later reads return the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Station address loaded into the store at reset |
| wide16 | input | 1 | Selects the 2-byte width for small accesses |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the ring |
| cfg_load | input | 1 | Load pointer and count |
| cfg_addr | input | 16 | Pointer value to load |
| cfg_count | input | 16 | Count value to load |
| port_req | input | 1 | Data port access strobe |
| port_wr | input | 1 | 1 = write, 0 = read |
| port_size | input | 2 | Access size class (2 or 3 = 4 bytes) |
| port_wdata | input | 32 | Write data, little-endian |
| port_busy | output | 1 | Response cycle, strobes ignored |
| port_rvalid | output | 1 | Read data valid |
| port_rdata | output | 32 | Read data, little-endian |
| ram_en | output | 4 | Per-lane RAM enable |
| ram_we | output | 4 | Per-lane RAM write enable |
| ram_row | output | 48 | Per-lane row address, 12 bits per lane |
| ram_wdata | output | 32 | Per-lane write byte |
| ram_rdata | input | 32 | Per-lane read byte, one cycle after enable |
| cur_addr | output | 16 | Current remote pointer |
| cur_count | output | 16 | Remaining byte count |
| dma_done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the edges of the two address windows: a 4-byte read at 30 that spills past the store, a 4-byte access at 32766 that overruns packet memory, and addresses just outside each window. A design that checked only the start address would let the last of these write past memory, and one that mixed up the windows would return stored data where all ones are due. It also steps the pointer onto the stop page, runs unaligned 16-bit and 32-bit accesses, and writes with a zero count. A wrong wrap comparison shows up as a pointer that runs past the stop page, and a forgotten alignment shows up as bytes shifted by one lane. A missing zero-count guard lets a late write change memory or fire the completion pulse.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int PG_W   = 8;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int NB_W   = LANE_W + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [NB_W-1:0]   nb_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [PG_W-1:0]   page_t;

  typedef enum logic {ST_IDLE, ST_RESP} phase_e;

  // What the response cycle needs to know about the accepted access
  typedef struct packed {
    logic              wr;
    logic              skip;   // write with zero count: no update
    logic              ok;     // address inside a window
    logic              prom;   // store window
    nb_t               n;
    logic [LANE_W-1:0] ofs;    // lane holding the lowest byte
  } resp_t;

  function automatic nb_t access_bytes(logic wide, logic [1:0] size);
    if (size >= 2'd2) return nb_t'(LANES);
    return wide ? nb_t'(2) : nb_t'(1);
  endfunction

  function automatic addr_t align_addr(addr_t a, nb_t n);
    return (n > nb_t'(1)) ? {a[ADDR_W-1:1], 1'b0} : a;
  endfunction

  function automatic logic access_ok(addr_t a, nb_t n, int unsigned prom_n,
                                     int unsigned base, int unsigned top);
    int unsigned lo;
    int unsigned hi;
    lo = 32'(a);
    hi = lo + 32'(n);
    return (lo < prom_n) || (lo >= base && hi <= top);
  endfunction

  function automatic addr_t ring_next(addr_t a, nb_t n, page_t start_pg, page_t stop_pg);
    addr_t s;
    s = a + addr_t'(n);
    return (s == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : s;
  endfunction

  function automatic word_t fill_ones(nb_t n);
    word_t m;
    m = '0;
    for (int j = 0; j < LANES; j++)
      if (nb_t'(j) < n) m[8*j +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_fire,
  input  addr_t load_addr,
  input  cnt_t  load_cnt,
  input  logic  upd_fire,
  input  nb_t   step,
  input  page_t start_pg,
  input  page_t stop_pg,
  output addr_t cur_addr,
  output cnt_t  cur_count,
  output logic  done_pulse
);
  logic last_chunk;
  assign last_chunk = (cur_count <= cnt_t'(step));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      cur_count  <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (load_fire) begin
        cur_addr  <= load_addr;
        cur_count <= load_cnt;
      end else if (upd_fire) begin
        cur_addr <= ring_next(cur_addr, step, start_pg, stop_pg);
        if (last_chunk) begin
          cur_count  <= '0;
          done_pulse <= 1'b1;
        end else begin
          cur_count <= cur_count - cnt_t'(step);
        end
      end
    end
  end
endmodule

// File: rtl/rdma_prom.sv
module rdma_prom
  import rdma_pkg::*;
#(
  parameter int PROM_BYTES = 32,
  localparam int IDX_W = $clog2(PROM_BYTES)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] station,
  input  logic        wr_en,
  input  addr_t       addr,
  input  nb_t         n,
  input  word_t       wdata,
  output word_t       rdata
);
  logic [7:0] bytes_q [PROM_BYTES];

  // Reset image: each source byte appears twice in a row
  function automatic logic [7:0] seed_byte(int i, logic [47:0] st);
    int s;
    s = i / 2;
    if (s < 6) return st[8*s +: 8];
    if (s == 14 || s == 15) return 8'h57;
    return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PROM_BYTES; i++) bytes_q[i] <= seed_byte(i, station);
    end else if (wr_en) begin
      for (int j = 0; j < LANES; j++) begin
        if (nb_t'(j) < n && (32'(addr) + 32'(j)) < PROM_BYTES)
          bytes_q[IDX_W'(32'(addr) + 32'(j))] <= wdata[8*j +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < LANES; j++) begin
      if (nb_t'(j) < n && (32'(addr) + 32'(j)) < PROM_BYTES)
        rdata[8*j +: 8] = bytes_q[IDX_W'(32'(addr) + 32'(j))];
    end
  end
endmodule

// File: rtl/rdma_lane_map.sv
module rdma_lane_map
  import rdma_pkg::*;
#(
  parameter int BASE  = 16384,
  parameter int ROW_W = 12,
  localparam int OFS_W = ROW_W + LANE_W
)(
  input  logic                    acc_en,
  input  logic                    acc_we,
  input  addr_t                   acc_addr,
  input  nb_t                     acc_n,
  input  word_t                   acc_wdata,
  output logic [LANE_W-1:0]       acc_ofs,
  output logic [LANES-1:0]        ram_en,
  output logic [LANES-1:0]        ram_we,
  output logic [LANES*ROW_W-1:0]  ram_row,
  output word_t                   ram_wdata,
  input  logic [LANE_W-1:0]       rsp_ofs,
  input  nb_t                     rsp_n,
  input  word_t                   ram_rdata,
  output word_t                   rd_word
);
  logic [OFS_W-1:0] off;
  assign off     = OFS_W'(acc_addr - addr_t'(BASE));
  assign acc_ofs = off[LANE_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] j;
    logic [OFS_W-1:0]  boff;
    always_comb begin
      j    = LANE_W'(k) - off[LANE_W-1:0];
      boff = off + OFS_W'(j);
      ram_en[k] = acc_en && (nb_t'(j) < acc_n);
      ram_we[k] = acc_en && acc_we && (nb_t'(j) < acc_n);
      ram_row[k*ROW_W +: ROW_W] = boff[OFS_W-1:LANE_W];
      ram_wdata[8*k +: 8] = acc_wdata[8*j +: 8];
    end
  end

  always_comb begin
    logic [LANE_W-1:0] ln;
    rd_word = '0;
    for (int b = 0; b < LANES; b++) begin
      ln = rsp_ofs + LANE_W'(b);
      if (nb_t'(b) < rsp_n) rd_word[8*b +: 8] = ram_rdata[8*ln +: 8];
    end
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int PROM_BYTES = 32,
  parameter int PMEM_BASE  = 16384,
  parameter int MEM_BYTES  = 32768,
  localparam int ROW_W = $clog2((MEM_BYTES - PMEM_BASE) / LANES)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [47:0]            station_addr,
  input  logic                   wide16,
  input  logic [7:0]             ring_start_pg,
  input  logic [7:0]             ring_stop_pg,
  input  logic                   cfg_load,
  input  logic [15:0]            cfg_addr,
  input  logic [15:0]            cfg_count,
  input  logic                   port_req,
  input  logic                   port_wr,
  input  logic [1:0]             port_size,
  input  logic [31:0]            port_wdata,
  output logic                   port_busy,
  output logic                   port_rvalid,
  output logic [31:0]            port_rdata,
  output logic [LANES-1:0]       ram_en,
  output logic [LANES-1:0]       ram_we,
  output logic [LANES*ROW_W-1:0] ram_row,
  output logic [31:0]            ram_wdata,
  input  logic [31:0]            ram_rdata,
  output logic [15:0]            cur_addr,
  output logic [15:0]            cur_count,
  output logic                   dma_done
);
  phase_e phase_q;
  resp_t  rsp_q;
  word_t  prom_q;

  // Named events, also used by the bound checker
  logic  accept, load_fire, upd_fire;
  nb_t   acc_n;
  addr_t acc_ea;
  logic  acc_ok, acc_prom, acc_pmem, acc_write;
  logic  prom_we, pmem_en;
  logic [LANE_W-1:0] acc_ofs;
  word_t prom_rd, lane_rd;

  assign port_busy = (phase_q == ST_RESP);
  assign load_fire = cfg_load && !port_busy;
  assign accept    = port_req && !port_busy && !cfg_load;
  assign upd_fire  = port_busy && !rsp_q.skip;

  assign acc_n     = access_bytes(wide16, port_size);
  assign acc_ea    = align_addr(cur_addr, acc_n);
  assign acc_ok    = access_ok(acc_ea, acc_n, PROM_BYTES, PMEM_BASE, MEM_BYTES);
  assign acc_prom  = acc_ok && (32'(acc_ea) < PROM_BYTES);
  assign acc_pmem  = acc_ok && !acc_prom;
  assign acc_write = port_wr && (cur_count != '0);

  assign prom_we = accept && acc_write && acc_prom;
  assign pmem_en = accept && acc_pmem && (acc_write || !port_wr);

  rdma_ptr u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_fire  (load_fire),
    .load_addr  (cfg_addr),
    .load_cnt   (cfg_count),
    .upd_fire   (upd_fire),
    .step       (rsp_q.n),
    .start_pg   (ring_start_pg),
    .stop_pg    (ring_stop_pg),
    .cur_addr   (cur_addr),
    .cur_count  (cur_count),
    .done_pulse (dma_done)
  );

  rdma_prom #(.PROM_BYTES(PROM_BYTES)) u_prom (
    .clk     (clk),
    .rst_n   (rst_n),
    .station (station_addr),
    .wr_en   (prom_we),
    .addr    (acc_ea),
    .n       (acc_n),
    .wdata   (port_wdata),
    .rdata   (prom_rd)
  );

  rdma_lane_map #(.BASE(PMEM_BASE), .ROW_W(ROW_W)) u_lanes (
    .acc_en    (pmem_en),
    .acc_we    (port_wr),
    .acc_addr  (acc_ea),
    .acc_n     (acc_n),
    .acc_wdata (port_wdata),
    .acc_ofs   (acc_ofs),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_row   (ram_row),
    .ram_wdata (ram_wdata),
    .rsp_ofs   (rsp_q.ofs),
    .rsp_n     (rsp_q.n),
    .ram_rdata (ram_rdata),
    .rd_word   (lane_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      rsp_q   <= '0;
      prom_q  <= '0;
    end else if (accept) begin
      phase_q    <= ST_RESP;
      rsp_q.wr   <= port_wr;
      rsp_q.skip <= port_wr && (cur_count == '0);
      rsp_q.ok   <= acc_ok;
      rsp_q.prom <= acc_prom;
      rsp_q.n    <= acc_n;
      rsp_q.ofs  <= acc_ofs;
      prom_q     <= prom_rd;
    end else begin
      phase_q <= ST_IDLE;
    end
  end

  assign port_rvalid = port_busy && !rsp_q.wr;

  always_comb begin
    port_rdata = '0;
    if (port_rvalid) begin
      if (!rsp_q.ok)      port_rdata = fill_ones(rsp_q.n);
      else if (rsp_q.prom) port_rdata = prom_q;
      else                port_rdata = lane_rd;
    end
  end
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk
  import rdma_pkg::*;
#(
  parameter int LN = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          load_fire,
  input logic          upd_fire,
  input logic          acc_ok,
  input logic          prom_we,
  input logic          port_wr,
  input logic          port_busy,
  input logic          port_rvalid,
  input logic          dma_done,
  input logic          cfg_load,
  input logic [LN-1:0] ram_en,
  input logic [LN-1:0] ram_we,
  input logic [15:0]   cur_addr,
  input logic [15:0]   cur_count,
  input logic [7:0]    ring_start_pg,
  input logic [7:0]    ring_stop_pg
);
  p_resp_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> port_busy);
  p_busy_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |=> !port_busy);
  p_rvalid_from_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    port_rvalid |-> $past(accept && !port_wr));
  p_done_after_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> ($past(port_busy) && cur_count == 16'd0));
  p_count_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_fire) |-> cur_count <= $past(cur_count));
  p_ring_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && ring_start_pg != ring_stop_pg && $stable(ring_stop_pg))
      |=> cur_addr != {ring_stop_pg, 8'h00});
  p_zero_count_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && port_wr && cur_count == 16'd0) |-> (ram_we == '0 && !prom_we));
  p_invalid_no_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !acc_ok) |-> (ram_en == '0 && !prom_we));
  p_load_drops_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !port_busy) |=> !port_busy);
  p_we_within_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we & ~ram_en) == '0);
endmodule

bind rdma_port_engine rdma_port_engine_chk #(.LN(rdma_pkg::LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (accept),
  .load_fire     (load_fire),
  .upd_fire      (upd_fire),
  .acc_ok        (acc_ok),
  .prom_we       (prom_we),
  .port_wr       (port_wr),
  .port_busy     (port_busy),
  .port_rvalid   (port_rvalid),
  .dma_done      (dma_done),
  .cfg_load      (cfg_load),
  .ram_en        (ram_en),
  .ram_we        (ram_we),
  .cur_addr      (cur_addr),
  .cur_count     (cur_count),
  .ring_start_pg (ring_start_pg),
  .ring_stop_pg  (ring_stop_pg)
);

// File: tb/test_rdma_port_engine.sv
`timescale 1ns/1ps
module test_rdma_port_engine;
  localparam int ROWW = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [47:0] station_addr = 48'h665544332211;
  logic wide16 = 1'b0;
  logic [7:0] ring_start_pg = 8'h40, ring_stop_pg = 8'h80;
  logic cfg_load = 1'b0;
  logic [15:0] cfg_addr = '0, cfg_count = '0;
  logic port_req = 1'b0, port_wr = 1'b0;
  logic [1:0] port_size = '0;
  logic [31:0] port_wdata = '0;
  logic port_busy, port_rvalid, dma_done;
  logic [31:0] port_rdata, ram_wdata;
  logic [31:0] ram_rdata = '0;
  logic [3:0] ram_en, ram_we;
  logic [4*ROWW-1:0] ram_row;
  logic [15:0] cur_addr, cur_count;

  always #5 clk = ~clk;

  rdma_port_engine i_rdma_port_engine (.*);

  // Lane RAM model, keyed lane*4096+row
  logic [7:0] ram [int];
  int we_pulses = 0;
  always @(posedge clk) begin
    if (|ram_we) we_pulses++;
    for (int k = 0; k < 4; k++) begin
      if (ram_en[k]) begin
        int key;
        key = k * 4096 + int'(ram_row[k*ROWW +: ROWW]);
        if (ram_we[k]) ram[key] = ram_wdata[8*k +: 8];
        else ram_rdata[8*k +: 8] <= ram.exists(key) ? ram[key] : 8'h00;
      end
    end
  end

  // Reference state
  logic [7:0] m_prom [32];
  logic [7:0] m_mem [int];
  int m_addr = 0, m_count = 0;
  int n_cmp = 0, n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int e_bytes(bit wide, logic [1:0] sz);
    if (sz[1]) return 4;
    return wide ? 2 : 1;
  endfunction

  function automatic bit e_ok(int a, int n);
    return (a < 32) || (a >= 16384 && a + n <= 32768);
  endfunction

  function automatic logic [7:0] e_byte(int x);
    if (x < 32) return m_prom[x];
    if (m_mem.exists(x)) return m_mem[x];
    return 8'h00;
  endfunction

  function automatic logic [7:0] ram_at(int x);
    int key;
    key = ((x - 16384) % 4) * 4096 + (x - 16384) / 4;
    return ram.exists(key) ? ram[key] : 8'h00;
  endfunction

  task automatic do_load(int a, int c);
    @(negedge clk);
    cfg_load = 1'b1; cfg_addr = 16'(a); cfg_count = 16'(c);
    @(negedge clk);
    cfg_load = 1'b0;
    m_addr = a; m_count = c;
    chk("R11 load addr", 32'(cur_addr), 32'(a));
    chk("R11 load count", 32'(cur_count), 32'(c));
  endtask

  task automatic do_acc(bit wr, logic [1:0] sz, logic [31:0] wd, bit hold);
    int n, ea, nxt;
    bit ok, upd, done_e;
    logic [31:0] exp;
    n = e_bytes(wide16, sz);
    ea = (n > 1) ? (m_addr & ~1) : m_addr;
    ok = e_ok(ea, n);
    exp = '0;
    for (int j = 0; j < n; j++) begin
      if (!ok) exp[8*j +: 8] = 8'hFF;
      else if (ea < 32 && ea + j >= 32) exp[8*j +: 8] = 8'h00;
      else exp[8*j +: 8] = e_byte(ea + j);
    end
    @(negedge clk);
    port_req = 1'b1; port_wr = wr; port_size = sz; port_wdata = wd;
    @(negedge clk);
    if (!hold) port_req = 1'b0;
    chk("R10 busy", 32'(port_busy), 32'd1);
    chk("R10 rvalid", 32'(port_rvalid), 32'(!wr));
    if (!wr) chk("R2 R3 R4 R5 rdata", port_rdata, exp);
    @(negedge clk);
    port_req = 1'b0;
    upd = !(wr && m_count == 0);
    if (wr && m_count != 0 && ok)
      for (int j = 0; j < n; j++) begin
        if (ea < 32) begin
          if (ea + j < 32) m_prom[ea + j] = wd[8*j +: 8];
        end else m_mem[ea + j] = wd[8*j +: 8];
      end
    done_e = 1'b0;
    if (upd) begin
      nxt = (m_addr + n) & 16'hFFFF;
      if (nxt == int'(ring_stop_pg) * 256) nxt = int'(ring_start_pg) * 256;
      m_addr = nxt;
      if (m_count <= n) begin m_count = 0; done_e = 1'b1; end
      else m_count = m_count - n;
    end
    chk("R6 R8 pointer", 32'(cur_addr), 32'(m_addr));
    chk("R7 R8 count", 32'(cur_count), 32'(m_count));
    chk("R7 R9 done", 32'(dma_done), 32'(done_e));
    chk("R10 busy clear", 32'(port_busy), 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      int s;
      s = i / 2;
      m_prom[i] = (s < 6) ? station_addr[8*s +: 8] : ((s == 14 || s == 15) ? 8'h57 : 8'h00);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(port_busy), 32'd0);
    chk("R1 rvalid", 32'(port_rvalid), 32'd0);
    chk("R1 done", 32'(dma_done), 32'd0);
    chk("R1 addr", 32'(cur_addr), 32'd0);
    chk("R1 count", 32'(cur_count), 32'd0);
    // R1: store image read byte by byte
    do_load(0, 32);
    for (int i = 0; i < 32; i++) do_acc(1'b0, 2'd0, 32'h0, 1'b0);
    // R2/R3: 16-bit and 32-bit little-endian round trip, unaligned pointer
    do_load(16384, 16);
    wide16 = 1'b0;
    do_acc(1'b1, 2'd0, 32'h000000A5, 1'b0);
    chk("R4 lane map", 32'(ram_at(16384)), 32'hA5);
    wide16 = 1'b1;
    do_load(16387, 16);
    do_acc(1'b1, 2'd1, 32'h0000BEEF, 1'b0);
    chk("R4 lane map lo", 32'(ram_at(16386)), 32'hEF);
    chk("R4 lane map hi", 32'(ram_at(16387)), 32'hBE);
    do_load(16390, 16);
    do_acc(1'b1, 2'd2, 32'h44332211, 1'b0);
    chk("R4 lane map w", 32'(ram_at(16393)), 32'h44);
    do_load(16385, 16);
    do_acc(1'b0, 2'd2, 32'h0, 1'b0);
    do_acc(1'b0, 2'd3, 32'h0, 1'b0);
    // R4/R5: window edges
    do_load(30, 8);
    do_acc(1'b0, 2'd2, 32'h0, 1'b0);
    do_load(100, 8);
    w0 = we_pulses;
    do_acc(1'b1, 2'd2, 32'hDEADBEEF, 1'b0);
    chk("R5 no write", 32'(we_pulses), 32'(w0));
    do_acc(1'b0, 2'd1, 32'h0, 1'b0);
    do_load(32766, 8);
    do_acc(1'b1, 2'd2, 32'h12345678, 1'b0);
    chk("R5 no write edge", 32'(we_pulses), 32'(w0));
    do_acc(1'b0, 2'd2, 32'h0, 1'b0);
    wide16 = 1'b0;
    do_load(16383, 8);
    do_acc(1'b0, 2'd0, 32'h0, 1'b0);
    // R12: store window write
    wide16 = 1'b1;
    do_load(4, 4);
    do_acc(1'b1, 2'd1, 32'h00009A8B, 1'b0);
    do_load(4, 4);
    do_acc(1'b0, 2'd1, 32'h0, 1'b0);
    // R6: ring wrap onto the stop page
    ring_start_pg = 8'h46; ring_stop_pg = 8'h48;
    wide16 = 1'b0;
    do_load(16'h47FF, 4);
    do_acc(1'b0, 2'd0, 32'h0, 1'b0);
    chk("R6 wrapped", 32'(cur_addr), 32'h4600);
    // R8/R9: zero count
    do_load(16'h4610, 0);
    w0 = we_pulses;
    do_acc(1'b1, 2'd0, 32'h77, 1'b0);
    chk("R8 no write", 32'(we_pulses), 32'(w0));
    do_acc(1'b0, 2'd0, 32'h0, 1'b0);
    // R10: strobe held through busy counts once
    do_load(16'h4620, 9);
    do_acc(1'b0, 2'd0, 32'h0, 1'b1);
    // R11: load beats a same-cycle strobe
    @(negedge clk);
    cfg_load = 1'b1; cfg_addr = 16'h4630; cfg_count = 16'd5; port_req = 1'b1; port_wr = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0; port_req = 1'b0;
    chk("R11 strobe dropped", 32'(port_busy), 32'd0);
    chk("R11 addr", 32'(cur_addr), 32'h4630);
    m_addr = 16'h4630; m_count = 5;
    // Random mix
    ring_start_pg = 8'h40; ring_stop_pg = 8'h80;
    for (int it = 0; it < 500; it++) begin
      int r;
      r = int'($urandom % 100);
      wide16 = 1'($urandom);
      if (r < 12) begin
        int region, a;
        region = int'($urandom % 5);
        case (region)
          0: a = int'($urandom % 40);
          1: a = 16378 + int'($urandom % 16);
          2: a = 32758 + int'($urandom % 10);
          3: a = int'(ring_stop_pg) * 256 - int'($urandom % 8) - 1;
          default: a = 16384 + int'($urandom % 16384);
        endcase
        do_load(a & 16'hFFFF, int'($urandom % 9));
      end else if (r < 15) begin
        int sp;
        @(negedge clk);
        sp = 16'h40 + int'($urandom % 32);
        ring_start_pg = 8'(sp);
        ring_stop_pg = 8'(sp + 1 + int'($urandom % 31));
      end else begin
        do_acc(1'($urandom), 2'($urandom), $urandom, 1'b0);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule